// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is the packet switch for one tile of a two-dimensional mesh of dynamic networks. It joins five ports: the four neighbouring tiles (north, south, east, west) and the tile's own processor. Every port is a pair of 32-bit one-way links, one in and one out, and each link carries credit-based flow control. Each input link feeds a small buffer in the router. Each output link keeps a count of the free buffer slots in the next hop. A word never leaves on a link unless the next hop has a free slot for it, so no word is ever lost.

A packet starts with a header word. The header gives the destination column and row and the number of payload words that follow it. The router sends the packet in dimension order. It corrects the column first, then the row, and gives the packet to the local processor when both coordinates match. An output picks one waiting header by round-robin. It then stays bound to that input until the number of payload words stated in the header has passed. Only after that can another input use the output. The tile's own coordinates come in on static inputs, so the same block can be placed at any grid position.

Top module: `mesh_router`

## Requirements
- R1: During reset, and until traffic arrives after it, every out_valid bit and every in_credit bit is low.
- R2: A header word holds the destination column in bits 2:0 and the destination row in bits 5:3. Bits 23:16 hold the payload length, which is the number of words that follow the header, from 0 to 128 (128 is 8'h80). Every word, the header included, leaves the router unchanged.
- R3: Ports are numbered 0 local, 1 north, 2 south, 3 east and 4 west. The router sends a header to an output chosen in this order:
  - east, if the destination column is greater than tile_x;
  - west, if it is smaller;
  - otherwise north, if the destination row is greater than tile_y;
  - south, if the row is smaller;
  - otherwise local.
- R4: On an output, a packet's header and all of its payload words appear in order and back to back. No word from any other input appears between them.
- R5: When several headers wait for a free output, the output grants them in rotating order. It starts with the input just after the one it granted last, and input 0 has first priority after reset. The order changes only at packet boundaries.
- R6: Each output starts with 4 credits and uses one for every word it sends. It sends nothing while it holds no credit. When credits come back, it resumes with no word lost or repeated.
- R7: Each input buffer holds 4 words. For every word the router accepts on an input, it returns exactly one in_credit pulse on that input once the word has left the buffer.
- R8: A packet of length 0 is a single header word. It frees its output at once, so headers of length 0 sent back to back from one input come out one after another and in order.
- R9: Packets bound for different outputs move at the same time, and neither one changes the other's content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tile_x | input | 3 | Column of this tile |
| tile_y | input | 3 | Row of this tile |
| in_valid | input | 5 | One bit per input port: a word is present this cycle |
| in_data | input | 5x32 | Word for each input port |
| in_credit | output | 5 | One bit per input port: one buffer slot has been freed, credit returned upstream |
| out_valid | output | 5 | One bit per output port: a word is present this cycle |
| out_data | output | 5x32 | Word for each output port |
| out_credit | input | 5 | One bit per output port: the downstream side returns one credit |

## Verification
The bench sends a packet from each input to every destination of the grid. It does this from a central tile and from two corner tiles, with lengths that include zero. A wrong comparison in the routing would send the packet to the wrong output, and a miscounted length would cut the packet short or merge two packets together. Competing headers are released in groups that make the round-robin pointer wrap around and restart in the middle, so an arbiter that uses fixed priority, or that moves its pointer on every word, gives a different packet order. The tests also check that an output does not interleave two long packets. They hold back credits downstream, so an output that sends without a credit shows more than four words while it is stalled. Finally, they check that every upstream credit comes back, so a router that drops or doubles credit pulses leaves the sender's count wrong.

// File: rtl/mesh_rtr_pkg.sv
package mesh_rtr_pkg;

   localparam int NUM_PORTS = 5;

   typedef enum logic [2:0] {
      PORT_LOCAL = 3'd0,
      PORT_NORTH = 3'd1,
      PORT_SOUTH = 3'd2,
      PORT_EAST  = 3'd3,
      PORT_WEST  = 3'd4
   } port_e;

endpackage

// File: rtl/rtr_in_fifo.sv
module rtr_in_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          not_empty
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("rtr_in_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;
   logic [AW:0]   fill;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_ptr] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
         end
         if (rd_en) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
         fill <= fill + (AW+1)'(wr_en) - (AW+1)'(rd_en);
      end
   end

   assign rd_data   = mem[rd_ptr];
   assign not_empty = (fill != '0);

endmodule

// File: rtl/rtr_route.sv
module rtr_route
   import mesh_rtr_pkg::*;
#(
   parameter int COORD_W = 3
) (
   input  logic [COORD_W-1:0] dest_x,
   input  logic [COORD_W-1:0] dest_y,
   input  logic [COORD_W-1:0] here_x,
   input  logic [COORD_W-1:0] here_y,
   output port_e              dir
);

   always_comb begin
      if (dest_x > here_x) begin
         dir = PORT_EAST;
      end else if (dest_x < here_x) begin
         dir = PORT_WEST;
      end else if (dest_y > here_y) begin
         dir = PORT_NORTH;
      end else if (dest_y < here_y) begin
         dir = PORT_SOUTH;
      end else begin
         dir = PORT_LOCAL;
      end
   end

endmodule

// File: rtl/rtr_out_port.sv
module rtr_out_port #(
   parameter int NP      = 5,
   parameter int DW      = 32,
   parameter int LEN_W   = 8,
   parameter int CREDITS = 4,
   localparam int PW     = $clog2(NP)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NP-1:0]             hdr_req,
   input  logic [NP-1:0]             head_valid,
   input  logic [NP-1:0][DW-1:0]     head_data,
   input  logic [NP-1:0][LEN_W-1:0]  head_len,
   input  logic                      credit_in,
   output logic [NP-1:0]             grant,
   output logic                      out_valid,
   output logic [DW-1:0]             out_data,
   output logic                      locked,
   output logic [PW-1:0]             owner
);

   localparam int CW = $clog2(CREDITS + 1);

   if (CREDITS < 1) begin : g_bad_credits
      $error("rtr_out_port: CREDITS must be at least 1");
   end

   logic [CW-1:0]    cred;
   logic [LEN_W-1:0] remain;
   logic [PW-1:0]    rr_ptr;
   logic [PW-1:0]    winner;
   logic             found;
   logic             has_cred;
   logic             hdr_fire;
   logic             body_fire;
   logic             fire;
   logic [PW-1:0]    sel;

   always_comb begin
      int idx;
      found  = 1'b0;
      winner = '0;
      for (int k = 0; k < NP; k++) begin
         idx = (int'(rr_ptr) + k) % NP;
         if (!found && hdr_req[idx]) begin
            found  = 1'b1;
            winner = PW'(idx);
         end
      end
   end

   assign has_cred  = (cred != '0);
   assign hdr_fire  = !locked && found && has_cred;
   assign body_fire = locked && head_valid[owner] && has_cred;
   assign fire      = hdr_fire || body_fire;
   assign sel       = locked ? owner : winner;

   always_comb begin
      grant = '0;
      if (fire) begin
         grant[sel] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cred      <= CW'(CREDITS);
         locked    <= 1'b0;
         owner     <= '0;
         remain    <= '0;
         rr_ptr    <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= fire;
         if (fire) begin
            out_data <= head_data[sel];
         end
         cred <= cred + CW'(credit_in) - CW'(fire);
         if (hdr_fire) begin
            rr_ptr <= (winner == PW'(NP - 1)) ? '0 : winner + 1'b1;
            if (head_len[winner] != '0) begin
               locked <= 1'b1;
               owner  <= winner;
               remain <= head_len[winner];
            end
         end
         if (body_fire) begin
            remain <= remain - 1'b1;
            if (remain == LEN_W'(1)) begin
               locked <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/mesh_router.sv
module mesh_router
   import mesh_rtr_pkg::*;
#(
   parameter int DW           = 32,
   parameter int COORD_W      = 3,
   parameter int LEN_W        = 8,
   parameter int X_LSB        = 0,
   parameter int Y_LSB        = 3,
   parameter int LEN_LSB      = 16,
   parameter int MAX_LEN      = 128,
   parameter int FIFO_DEPTH   = 4,
   parameter int DOWN_CREDITS = 4,
   localparam int NP          = NUM_PORTS,
   localparam int PW          = $clog2(NP)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [COORD_W-1:0]     tile_x,
   input  logic [COORD_W-1:0]     tile_y,
   input  logic [NP-1:0]          in_valid,
   input  logic [NP-1:0][DW-1:0]  in_data,
   output logic [NP-1:0]          in_credit,
   output logic [NP-1:0]          out_valid,
   output logic [NP-1:0][DW-1:0]  out_data,
   input  logic [NP-1:0]          out_credit
);

   if (X_LSB + COORD_W > DW || Y_LSB + COORD_W > DW || LEN_LSB + LEN_W > DW) begin : g_bad_fields
      $error("mesh_router: header fields exceed the word width");
   end
   if (MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("mesh_router: LEN_W too narrow for MAX_LEN");
   end

   logic [NP-1:0][DW-1:0]    head_data;
   logic [NP-1:0]            head_valid;
   logic [NP-1:0][LEN_W-1:0] head_len;
   port_e                    route_dir [NP];
   logic [NP-1:0]            busy;
   logic [NP-1:0]            hdr_req;
   logic [NP-1:0][NP-1:0]    req_to;
   logic [NP-1:0][NP-1:0]    gnt;
   logic [NP-1:0]            pop;
   logic [NP-1:0]            lock_vec;
   logic [NP-1:0][PW-1:0]    owner_vec;

   for (genvar i = 0; i < NP; i++) begin : g_in
      rtr_in_fifo #(
         .DW    (DW),
         .DEPTH (FIFO_DEPTH)
      ) u_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (in_valid[i]),
         .wr_data   (in_data[i]),
         .rd_en     (pop[i]),
         .rd_data   (head_data[i]),
         .not_empty (head_valid[i])
      );

      assign head_len[i] = head_data[i][LEN_LSB +: LEN_W];

      rtr_route #(
         .COORD_W (COORD_W)
      ) u_route (
         .dest_x (head_data[i][X_LSB +: COORD_W]),
         .dest_y (head_data[i][Y_LSB +: COORD_W]),
         .here_x (tile_x),
         .here_y (tile_y),
         .dir    (route_dir[i])
      );
   end

   always_comb begin
      busy = '0;
      for (int i = 0; i < NP; i++) begin
         for (int o = 0; o < NP; o++) begin
            if (lock_vec[o] && owner_vec[o] == PW'(i)) begin
               busy[i] = 1'b1;
            end
         end
      end
   end

   assign hdr_req = head_valid & ~busy;

   always_comb begin
      for (int o = 0; o < NP; o++) begin
         for (int i = 0; i < NP; i++) begin
            req_to[o][i] = hdr_req[i] && (route_dir[i] == port_e'(o));
         end
      end
   end

   always_comb begin
      pop = '0;
      for (int o = 0; o < NP; o++) begin
         pop = pop | gnt[o];
      end
   end

   for (genvar o = 0; o < NP; o++) begin : g_out
      rtr_out_port #(
         .NP      (NP),
         .DW      (DW),
         .LEN_W   (LEN_W),
         .CREDITS (DOWN_CREDITS)
      ) u_port (
         .clk        (clk),
         .rst_n      (rst_n),
         .hdr_req    (req_to[o]),
         .head_valid (head_valid),
         .head_data  (head_data),
         .head_len   (head_len),
         .credit_in  (out_credit[o]),
         .grant      (gnt[o]),
         .out_valid  (out_valid[o]),
         .out_data   (out_data[o]),
         .locked     (lock_vec[o]),
         .owner      (owner_vec[o])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_credit <= '0;
      end else begin
         in_credit <= pop;
      end
   end

endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk #(
   parameter int NP           = 5,
   parameter int DW           = 32,
   parameter int COORD_W      = 3,
   parameter int LEN_W        = 8,
   parameter int X_LSB        = 0,
   parameter int Y_LSB        = 3,
   parameter int LEN_LSB      = 16,
   parameter int DOWN_CREDITS = 4,
   localparam int PW          = $clog2(NP)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [COORD_W-1:0]    tile_x,
   input logic [COORD_W-1:0]    tile_y,
   input logic [NP-1:0]         in_valid,
   input logic [NP-1:0]         in_credit,
   input logic [NP-1:0]         out_valid,
   input logic [NP-1:0][DW-1:0] out_data,
   input logic [NP-1:0]         out_credit,
   input logic [NP-1:0][NP-1:0] gnt,
   input logic [NP-1:0]         lock_vec,
   input logic [NP-1:0][PW-1:0] owner_vec
);

   int               down_cnt [NP];
   int               occ      [NP];
   logic [LEN_W-1:0] orem     [NP];
   logic [NP-1:0][NP-1:0] col;
   logic             unused_bits;

   assign unused_bits = ^out_data;

   function automatic logic [2:0] want_dir(input logic [COORD_W-1:0] dx, input logic [COORD_W-1:0] dy,
                                           input logic [COORD_W-1:0] hx, input logic [COORD_W-1:0] hy);
      if (dx > hx) return 3'd3;
      if (dx < hx) return 3'd4;
      if (dy > hy) return 3'd1;
      if (dy < hy) return 3'd2;
      return 3'd0;
   endfunction

   always_comb begin
      for (int i = 0; i < NP; i++) begin
         for (int o = 0; o < NP; o++) begin
            col[i][o] = gnt[o][i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NP; p++) begin
            down_cnt[p] <= DOWN_CREDITS;
            occ[p]      <= 0;
            orem[p]     <= '0;
         end
      end else begin
         for (int p = 0; p < NP; p++) begin
            down_cnt[p] <= down_cnt[p] + int'(out_credit[p]) - int'(out_valid[p]);
            occ[p]      <= occ[p] + int'(in_valid[p]) - int'(in_credit[p]);
            if (out_valid[p]) begin
               if (orem[p] == '0) begin
                  orem[p] <= out_data[p][LEN_LSB +: LEN_W];
               end else begin
                  orem[p] <= orem[p] - 1'b1;
               end
            end
         end
      end
   end

   for (genvar p = 0; p < NP; p++) begin : g_chk
      // R6: a word leaves only against a credit held for the next hop
      assert_credit_respected_R6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[p] |-> (down_cnt[p] > 0));

      // R7: a credit goes back only for a word that was received
      assert_credit_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
         in_credit[p] |-> (occ[p] > 0));

      // R3: every header leaves on the dimension-order port
      assert_header_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[p] && orem[p] == '0) |->
            (want_dir(out_data[p][X_LSB +: COORD_W], out_data[p][Y_LSB +: COORD_W], tile_x, tile_y) == 3'(p)));

      // R4: an input buffer is drained by at most one output per cycle
      assert_single_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(col[p]));

      // R5: an output grants at most one input per cycle
      assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(gnt[p]));

      // R4: a bound output keeps its owner until it is released
      assert_owner_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
         lock_vec[p] |=> (!lock_vec[p] || owner_vec[p] == $past(owner_vec[p])));
   end

endmodule

bind mesh_router mesh_router_chk #(
   .NP           (NP),
   .DW           (DW),
   .COORD_W      (COORD_W),
   .LEN_W        (LEN_W),
   .X_LSB        (X_LSB),
   .Y_LSB        (Y_LSB),
   .LEN_LSB      (LEN_LSB),
   .DOWN_CREDITS (DOWN_CREDITS)
) u_chk (.*);

// File: tb/tb_mesh_router.sv
module tb_mesh_router;

   localparam int NP    = 5;
   localparam int DW    = 32;
   localparam int DEPTH = 4;

   logic                  clk = 1'b0;
   logic                  rst_n;
   logic [2:0]            tile_x;
   logic [2:0]            tile_y;
   logic [NP-1:0]         in_valid;
   logic [NP-1:0][DW-1:0] in_data;
   logic [NP-1:0]         in_credit;
   logic [NP-1:0]         out_valid;
   logic [NP-1:0][DW-1:0] out_data;
   logic [NP-1:0]         out_credit;

   always #5 clk = ~clk;

   mesh_router dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tile_x     (tile_x),
      .tile_y     (tile_y),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_credit  (in_credit),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_credit (out_credit)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [31:0] txq  [NP][512];
   int          tx_n [NP];
   int          tx_p [NP];
   int          up_cred [NP];
   logic [31:0] rxq  [NP][1024];
   int          rx_n [NP];
   int          owed [NP];
   bit          cred_en [NP];
   logic [31:0] expq [NP][1024];
   int          exp_n [NP];

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what, input longint act, input longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int exp_port(input int dx, input int dy, input int tx, input int ty);
      if (dx > tx) return 3;
      if (dx < tx) return 4;
      if (dy > ty) return 1;
      if (dy < ty) return 2;
      return 0;
   endfunction

   function automatic logic [31:0] hdr_word(input int dx, input int dy, input int len, input int tag);
      return {8'(tag), 8'(len), 10'd0, 3'(dy), 3'(dx)};
   endfunction

   function automatic logic [31:0] pay_word(input int tag, input int p, input int k);
      return {8'(tag), 8'(p), 16'(k)};
   endfunction

   // link models: senders and receivers act on the falling edge
   initial begin
      in_valid   = '0;
      in_data    = '0;
      out_credit = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
               if (in_credit[p]) up_cred[p]++;
               if (out_valid[p]) begin
                  rxq[p][rx_n[p]] = out_data[p];
                  rx_n[p]++;
                  owed[p]++;
               end
               in_valid[p] = 1'b0;
               if (tx_p[p] < tx_n[p] && up_cred[p] > 0) begin
                  in_valid[p] = 1'b1;
                  in_data[p]  = txq[p][tx_p[p]];
                  tx_p[p]++;
                  up_cred[p]--;
               end
               out_credit[p] = 1'b0;
               if (cred_en[p] && owed[p] > 0) begin
                  out_credit[p] = 1'b1;
                  owed[p]--;
               end
            end
         end else begin
            in_valid   = '0;
            out_credit = '0;
         end
      end
   end

   task automatic clear_queues();
      for (int p = 0; p < NP; p++) begin
         tx_n[p] = 0; tx_p[p] = 0; rx_n[p] = 0; exp_n[p] = 0;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(posedge clk);
      clear_queues();
      for (int p = 0; p < NP; p++) begin
         up_cred[p] = DEPTH; owed[p] = 0; cred_en[p] = 1'b1;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic push(input int p, input int dx, input int dy, input int len, input int tag);
      int e;
      e = exp_port(dx, dy, int'(tile_x), int'(tile_y));
      txq[p][tx_n[p]] = hdr_word(dx, dy, len, tag);
      expq[e][exp_n[e]] = hdr_word(dx, dy, len, tag);
      tx_n[p]++; exp_n[e]++;
      for (int k = 0; k < len; k++) begin
         txq[p][tx_n[p]] = pay_word(tag, p, k);
         expq[e][exp_n[e]] = pay_word(tag, p, k);
         tx_n[p]++; exp_n[e]++;
      end
   endtask

   function automatic bit all_sent();
      for (int p = 0; p < NP; p++) begin
         if (tx_p[p] < tx_n[p]) return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic wait_drain();
      while (!all_sent()) @(negedge clk);
      repeat (24) @(negedge clk);
   endtask

   task automatic cmp_stream(input int port, input string req);
      int bad;
      bad = -1;
      check(rx_n[port] == exp_n[port], req, $sformatf("word count on port %0d", port), rx_n[port], exp_n[port]);
      for (int k = 0; k < exp_n[port] && k < rx_n[port]; k++) begin
         if (bad < 0 && rxq[port][k] !== expq[port][k]) bad = k;
      end
      if (bad >= 0) begin
         check(1'b0, req, $sformatf("port %0d word %0d", port, bad), rxq[port][bad], expq[port][bad]);
      end else begin
         check(1'b1, req, "stream", 0, 0);
      end
   endtask

   task automatic check_all_ports(input string req);
      for (int p = 0; p < NP; p++) begin
         if (exp_n[p] != 0 || rx_n[p] != 0) cmp_stream(p, req);
      end
   endtask

   task automatic check_credits_home(input string req);
      bit ok;
      int bad_p;
      ok = 1'b1; bad_p = 0;
      for (int p = 0; p < NP; p++) begin
         if (up_cred[p] != DEPTH && ok) begin ok = 1'b0; bad_p = p; end
      end
      check(ok, req, $sformatf("upstream credits on input %0d", bad_p), up_cred[bad_p], DEPTH);
   endtask

   task automatic sweep(input int tx, input int ty, input int p_lo, input int p_hi);
      tile_x = 3'(tx); tile_y = 3'(ty);
      for (int p = p_lo; p <= p_hi; p++) begin
         for (int dx = 0; dx < 8; dx++) begin
            for (int dy = 0; dy < 8; dy++) begin
               clear_queues();
               push(p, dx, dy, (dx + 3 * dy + p) % 6, dx * 8 + dy);
               wait_drain();
               // R2 and R3: header fields decoded, packet exits on the DOR port only
               check_all_ports("R3");
               check_credits_home("R7");
            end
         end
      end
   endtask

   initial begin
      bit ok;
      logic [NP-1:0] seen_v, seen_c;
      rst_n = 1'b0; tile_x = 3'd3; tile_y = 3'd4;
      do_reset();

      // R1: outputs quiet after reset
      ok = 1'b1; seen_v = '0; seen_c = '0;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         seen_v = seen_v | out_valid;
         seen_c = seen_c | in_credit;
      end
      ok = (seen_v == '0) && (seen_c == '0);
      check(ok, "R1", "valid/credit after reset", {seen_v, seen_c}, 0);

      // R3 with R2 and R8: full destination sweep, lengths 0..5
      sweep(3, 4, 0, 4);
      sweep(0, 0, 0, 0);
      sweep(7, 7, 0, 0);

      // R2: maximum length 128 from north input, to the south
      tile_x = 3'd3; tile_y = 3'd4;
      clear_queues();
      push(1, 3, 0, 128, 8'h5A);
      wait_drain();
      check(rx_n[2] == 129, "R2", "words for length 128", rx_n[2], 129);
      cmp_stream(2, "R2");

      // R8: back-to-back zero-length headers from one input keep order
      clear_queues();
      push(2, 0, 4, 0, 1);
      push(2, 1, 4, 0, 2);
      push(2, 2, 4, 0, 3);
      push(2, 0, 2, 2, 4);
      wait_drain();
      cmp_stream(4, "R8");

      // R5: round robin, pointer starts at input 0 after reset
      do_reset();
      clear_queues();
      push(1, 3, 4, 3, 11);
      push(2, 3, 4, 3, 12);
      push(3, 3, 4, 3, 13);
      push(4, 3, 4, 3, 14);
      wait_drain();
      cmp_stream(0, "R5");
      // R5: pointer wraps past input 4 to input 0
      clear_queues();
      push(0, 3, 4, 2, 20);
      push(2, 3, 4, 2, 22);
      push(4, 3, 4, 2, 24);
      wait_drain();
      cmp_stream(0, "R5");
      // R5: pointer restarted in the middle by a lone grant to input 2
      clear_queues();
      push(2, 3, 4, 1, 30);
      wait_drain();
      clear_queues();
      push(3, 3, 4, 2, 33);
      push(4, 3, 4, 2, 34);
      push(0, 3, 4, 2, 35);
      push(1, 3, 4, 2, 36);
      wait_drain();
      cmp_stream(0, "R5");

      // R4: two long packets to east never interleave; R9: north runs alongside
      do_reset();
      clear_queues();
      push(1, 6, 4, 20, 41);
      push(4, 6, 4, 20, 44);
      push(0, 3, 7, 20, 40);
      wait_drain();
      cmp_stream(3, "R4");
      cmp_stream(1, "R9");
      check_credits_home("R7");

      // R6: downstream withholds credits on the local output
      do_reset();
      clear_queues();
      cred_en[0] = 1'b0;
      push(3, 3, 4, 10, 60);
      repeat (40) @(negedge clk);
      check(rx_n[0] == 4, "R6", "words sent with no credit back", rx_n[0], 4);
      cred_en[0] = 1'b1;
      wait_drain();
      cmp_stream(0, "R6");
      check_credits_home("R7");

      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         report();
      end
   end

endmodule